// File: doc/BRIEF.md
# 2D Blit Parameter Register Front-End

This block sits in front of a 2D block-transfer engine. It accepts register writes and keeps the parameters of the next transfer: source and destination coordinates, the width and height of the rectangle, per-side memory offset, pitch and tile flag, and a scissor bottom-right corner. Several fields can be loaded through more than one address. There are individual addresses and packed addresses that carry two 14-bit fields in one 32-bit word, in either order.

A write that carries a width launches the transfer. The block raises `startPulse` for one cycle, and the parameter outputs show the values from that write in the same cycle. A static input, `variantB`, chooses between two device variants. The variants differ in how the combined pitch/offset word is unpacked and in how direct offset and pitch writes are masked. The engine that moves pixels is outside this block and reads the parameter outputs when it sees the pulse.

Top module: `blit_param_frontend`

## Requirements
- R1: After reset every parameter output is zero and `startPulse` is low.
- R2: Individual coordinate writes keep only `wrData[13:0]`. The addresses are source X = 0, source Y = 1, destination X = 2, destination Y = 3, width = 4 and height = 5.
- R3: Packed writes carry two fields. Address 6 loads source and address 7 loads destination, each with X from `wrData[13:0]` and Y from `wrData[29:16]`. Address 8 loads source and address 9 loads destination, each with Y from the low field and X from the high field.
- R4: The following writes launch a transfer: width alone (address 4); width low with height high (address 10); height low with width high (address 11); destination X low with width high (address 12). `startPulse` is high for exactly the one cycle after the write, and in that cycle the outputs already hold the written values.
- R5: A write of height alone (address 5), of destination Y low with height high (address 13), or to any non-width address leaves `startPulse` low, and the fields it names are still loaded.
- R6: In variant A (`variantB` = 0), the combined pitch/offset word (source at address 18, destination at address 19) gives offset = `wrData[20:0]` shifted left by 5, pitch = `wrData[30:21]` and tile = `wrData[31]`.
- R7: In variant B, the same word gives offset = `wrData[21:0]` shifted left by 10, pitch = `wrData[29:22]` shifted left by 6 and tile = `wrData[30]`.
- R8: A direct offset write (source at address 14, destination at address 16) keeps `wrData & 0xFFFFFFF0` in variant A and `wrData & 0xFFFFFC00` in variant B.
- R9: A direct pitch write (source at address 15, destination at address 17) keeps `wrData[13:0]` as pitch and `wrData[16]` as tile in variant A. In variant B it keeps `wrData & 0x3FF0` as pitch and leaves tile unchanged.
- R10: The scissor write (address 20) keeps X from `wrData[13:0]` and Y from `wrData[29:16]`.
- R11: A write to an unmapped address (21 to 31), or a cycle with no write, changes no output and does not launch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| variantB | input | 1 | Static variant select, 0 = A, 1 = B |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 5 | Register word address |
| wrData | input | 32 | Write data |
| startPulse | output | 1 | One-cycle transfer start |
| srcX | output | 14 | Source X |
| srcY | output | 14 | Source Y |
| dstX | output | 14 | Destination X |
| dstY | output | 14 | Destination Y |
| width | output | 14 | Rectangle width |
| height | output | 14 | Rectangle height |
| srcOffset | output | 32 | Source memory offset |
| srcPitch | output | 14 | Source pitch |
| srcTile | output | 1 | Source tile flag |
| dstOffset | output | 32 | Destination memory offset |
| dstPitch | output | 14 | Destination pitch |
| dstTile | output | 1 | Destination tile flag |
| scissorX | output | 14 | Scissor right edge |
| scissorY | output | 14 | Scissor bottom edge |

## Verification
There is one register stage from a write to every result. A write presented before clock edge N shows its fields and any start pulse after edge N, and the pulse drops after edge N+1 unless another launching write follows. The bench drives each write on a falling edge and lowers the strobe on the next falling edge. It checks the fields and the pulse at that second falling edge, then waits one more falling edge to confirm the pulse has ended. When the bench changes variant, it applies reset again so that offsets and pitches written under the other variant do not carry over.

// File: rtl/blit_fe_pkg.sv
package blit_fe_pkg;
  localparam int ADDR_W  = 5;
  localparam int DATA_W  = 32;
  localparam int COORD_W = 14;
  localparam int HI_LSB  = 16;
  localparam int N_CRD   = 6;
  localparam int N_SIDE  = 2;

  localparam int CRD_SRCX = 0;
  localparam int CRD_SRCY = 1;
  localparam int CRD_DSTX = 2;
  localparam int CRD_DSTY = 3;
  localparam int CRD_WID  = 4;
  localparam int CRD_HGT  = 5;

  localparam int SIDE_SRC = 0;
  localparam int SIDE_DST = 1;

  typedef enum logic [ADDR_W-1:0] {
    A_SRCX      = 5'd0,
    A_SRCY      = 5'd1,
    A_DSTX      = 5'd2,
    A_DSTY      = 5'd3,
    A_WID       = 5'd4,
    A_HGT       = 5'd5,
    A_SRC_YX    = 5'd6,
    A_DST_YX    = 5'd7,
    A_SRC_XY    = 5'd8,
    A_DST_XY    = 5'd9,
    A_HGT_WID   = 5'd10,
    A_WID_HGT   = 5'd11,
    A_WID_X     = 5'd12,
    A_HGT_Y     = 5'd13,
    A_SRC_OFF   = 5'd14,
    A_SRC_PIT   = 5'd15,
    A_DST_OFF   = 5'd16,
    A_DST_PIT   = 5'd17,
    A_SRC_PKD   = 5'd18,
    A_DST_PKD   = 5'd19,
    A_SCISSOR   = 5'd20
  } regAddrE;

  typedef struct packed {
    logic [N_CRD-1:0]  crdLd;
    logic [N_CRD-1:0]  crdHi;
    logic [N_SIDE-1:0] offLd;
    logic [N_SIDE-1:0] pitLd;
    logic [N_SIDE-1:0] pkdLd;
    logic              sciLd;
    logic              launch;
  } strobeT;
endpackage

// File: rtl/blit_fe_ctrl.sv
module blit_fe_ctrl
  import blit_fe_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  output strobeT            strb,
  output logic              startPulse
);

  always_comb begin
    strb = '0;
    if (wrEn) begin
      case (wrAddr)
        A_SRCX:    strb.crdLd[CRD_SRCX] = 1'b1;
        A_SRCY:    strb.crdLd[CRD_SRCY] = 1'b1;
        A_DSTX:    strb.crdLd[CRD_DSTX] = 1'b1;
        A_DSTY:    strb.crdLd[CRD_DSTY] = 1'b1;
        A_WID:     strb.crdLd[CRD_WID]  = 1'b1;
        A_HGT:     strb.crdLd[CRD_HGT]  = 1'b1;
        A_SRC_YX: begin
          strb.crdLd[CRD_SRCX] = 1'b1;
          strb.crdLd[CRD_SRCY] = 1'b1;
          strb.crdHi[CRD_SRCY] = 1'b1;
        end
        A_DST_YX: begin
          strb.crdLd[CRD_DSTX] = 1'b1;
          strb.crdLd[CRD_DSTY] = 1'b1;
          strb.crdHi[CRD_DSTY] = 1'b1;
        end
        A_SRC_XY: begin
          strb.crdLd[CRD_SRCX] = 1'b1;
          strb.crdHi[CRD_SRCX] = 1'b1;
          strb.crdLd[CRD_SRCY] = 1'b1;
        end
        A_DST_XY: begin
          strb.crdLd[CRD_DSTX] = 1'b1;
          strb.crdHi[CRD_DSTX] = 1'b1;
          strb.crdLd[CRD_DSTY] = 1'b1;
        end
        A_HGT_WID: begin
          strb.crdLd[CRD_WID]  = 1'b1;
          strb.crdLd[CRD_HGT]  = 1'b1;
          strb.crdHi[CRD_HGT]  = 1'b1;
        end
        A_WID_HGT: begin
          strb.crdLd[CRD_HGT]  = 1'b1;
          strb.crdLd[CRD_WID]  = 1'b1;
          strb.crdHi[CRD_WID]  = 1'b1;
        end
        A_WID_X: begin
          strb.crdLd[CRD_DSTX] = 1'b1;
          strb.crdLd[CRD_WID]  = 1'b1;
          strb.crdHi[CRD_WID]  = 1'b1;
        end
        A_HGT_Y: begin
          strb.crdLd[CRD_DSTY] = 1'b1;
          strb.crdLd[CRD_HGT]  = 1'b1;
          strb.crdHi[CRD_HGT]  = 1'b1;
        end
        A_SRC_OFF: strb.offLd[SIDE_SRC] = 1'b1;
        A_SRC_PIT: strb.pitLd[SIDE_SRC] = 1'b1;
        A_DST_OFF: strb.offLd[SIDE_DST] = 1'b1;
        A_DST_PIT: strb.pitLd[SIDE_DST] = 1'b1;
        A_SRC_PKD: strb.pkdLd[SIDE_SRC] = 1'b1;
        A_DST_PKD: strb.pkdLd[SIDE_DST] = 1'b1;
        A_SCISSOR: strb.sciLd = 1'b1;
        default:   strb = '0;
      endcase
      strb.launch = strb.crdLd[CRD_WID];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) startPulse <= 1'b0;
    else       startPulse <= strb.launch;
  end

  AST_START_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |-> $past(wrEn)); // R4

  AST_HEIGHT_NO_START: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (wrAddr == A_HGT || wrAddr == A_HGT_Y)) |=> !startPulse); // R5

  AST_UNMAPPED_NO_START: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr > A_SCISSOR) |=> !startPulse); // R11

endmodule

// File: rtl/blit_fe_datapath.sv
module blit_fe_datapath
  import blit_fe_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    variantB,
  input  strobeT                  strb,
  input  logic [DATA_W-1:0]       wrData,
  output logic [N_CRD-1:0][COORD_W-1:0]  crd,
  output logic [N_SIDE-1:0][DATA_W-1:0]  offset,
  output logic [N_SIDE-1:0][COORD_W-1:0] pitch,
  output logic [N_SIDE-1:0]              tile,
  output logic [COORD_W-1:0]      sciX,
  output logic [COORD_W-1:0]      sciY
);

  localparam logic [DATA_W-1:0]  OFF_MASK_A = 32'hFFFF_FFF0;
  localparam logic [DATA_W-1:0]  OFF_MASK_B = 32'hFFFF_FC00;
  localparam logic [COORD_W-1:0] PIT_MASK_B = 14'h3FF0;
  localparam int TILE_BIT_DIRECT = 16;

  logic [COORD_W-1:0] loField, hiField;
  assign loField = wrData[COORD_W-1:0];
  assign hiField = wrData[HI_LSB +: COORD_W];

  for (genvar i = 0; i < N_CRD; i++) begin : g_crd
    always_ff @(posedge clk) begin
      if (!rstN)              crd[i] <= '0;
      else if (strb.crdLd[i]) crd[i] <= strb.crdHi[i] ? hiField : loField;
    end

    AST_CRD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      !strb.crdLd[i] |=> $stable(crd[i])); // R11
  end

  for (genvar c = 0; c < N_SIDE; c++) begin : g_side
    always_ff @(posedge clk) begin
      if (!rstN) begin
        offset[c] <= '0;
        pitch[c]  <= '0;
        tile[c]   <= 1'b0;
      end else if (strb.pkdLd[c]) begin
        if (variantB) begin
          offset[c] <= {wrData[21:0], 10'b0};
          pitch[c]  <= {wrData[29:22], 6'b0};
          tile[c]   <= wrData[30];
        end else begin
          offset[c] <= {6'b0, wrData[20:0], 5'b0};
          pitch[c]  <= {4'b0, wrData[30:21]};
          tile[c]   <= wrData[31];
        end
      end else begin
        if (strb.offLd[c])
          offset[c] <= wrData & (variantB ? OFF_MASK_B : OFF_MASK_A);
        if (strb.pitLd[c]) begin
          if (variantB) begin
            pitch[c] <= loField & PIT_MASK_B;
          end else begin
            pitch[c] <= loField;
            tile[c]  <= wrData[TILE_BIT_DIRECT];
          end
        end
      end
    end

    AST_OFF_ALIGN_A: assert property (@(posedge clk) disable iff (!rstN)
      !variantB |-> offset[c][3:0] == 4'b0); // R8

    AST_OFF_ALIGN_B: assert property (@(posedge clk) disable iff (!rstN)
      variantB |-> offset[c][9:0] == 10'b0); // R7

    AST_PITCH_ALIGN_B: assert property (@(posedge clk) disable iff (!rstN)
      variantB |-> pitch[c][3:0] == 4'b0); // R9
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sciX <= '0;
      sciY <= '0;
    end else if (strb.sciLd) begin
      sciX <= loField;
      sciY <= hiField;
    end
  end

  AST_SCI_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.sciLd |=> ($stable(sciX) && $stable(sciY))); // R10

endmodule

// File: rtl/blit_param_frontend.sv
module blit_param_frontend
  import blit_fe_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              variantB,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic              startPulse,
  output logic [COORD_W-1:0] srcX,
  output logic [COORD_W-1:0] srcY,
  output logic [COORD_W-1:0] dstX,
  output logic [COORD_W-1:0] dstY,
  output logic [COORD_W-1:0] width,
  output logic [COORD_W-1:0] height,
  output logic [DATA_W-1:0]  srcOffset,
  output logic [COORD_W-1:0] srcPitch,
  output logic               srcTile,
  output logic [DATA_W-1:0]  dstOffset,
  output logic [COORD_W-1:0] dstPitch,
  output logic               dstTile,
  output logic [COORD_W-1:0] scissorX,
  output logic [COORD_W-1:0] scissorY
);

  strobeT strb;
  logic [N_CRD-1:0][COORD_W-1:0]  crd;
  logic [N_SIDE-1:0][DATA_W-1:0]  offset;
  logic [N_SIDE-1:0][COORD_W-1:0] pitch;
  logic [N_SIDE-1:0]              tile;

  blit_fe_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .wrAddr     (wrAddr),
    .strb       (strb),
    .startPulse (startPulse)
  );

  blit_fe_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .variantB (variantB),
    .strb     (strb),
    .wrData   (wrData),
    .crd      (crd),
    .offset   (offset),
    .pitch    (pitch),
    .tile     (tile),
    .sciX     (scissorX),
    .sciY     (scissorY)
  );

  assign srcX      = crd[CRD_SRCX];
  assign srcY      = crd[CRD_SRCY];
  assign dstX      = crd[CRD_DSTX];
  assign dstY      = crd[CRD_DSTY];
  assign width     = crd[CRD_WID];
  assign height    = crd[CRD_HGT];
  assign srcOffset = offset[SIDE_SRC];
  assign dstOffset = offset[SIDE_DST];
  assign srcPitch  = pitch[SIDE_SRC];
  assign dstPitch  = pitch[SIDE_DST];
  assign srcTile   = tile[SIDE_SRC];
  assign dstTile   = tile[SIDE_DST];

  AST_START_WITH_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    (startPulse && !$past(startPulse)) |-> !$stable(width) || $past(wrEn)); // R4

endmodule

// File: tb/tb_blit_param_frontend.sv
`timescale 1ns/1ps
module tb_blit_param_frontend;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic variantB = 1'b0;
  logic wrEn = 1'b0;
  logic [4:0] wrAddr = '0;
  logic [31:0] wrData = '0;
  logic startPulse;
  logic [13:0] srcX, srcY, dstX, dstY, width, height;
  logic [31:0] srcOffset, dstOffset;
  logic [13:0] srcPitch, dstPitch, scissorX, scissorY;
  logic srcTile, dstTile;

  int total = 0;
  int fails = 0;

  always #5 clk = ~clk;

  blit_param_frontend dut (
    .clk(clk), .rstN(rstN), .variantB(variantB), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .startPulse(startPulse),
    .srcX(srcX), .srcY(srcY), .dstX(dstX), .dstY(dstY),
    .width(width), .height(height),
    .srcOffset(srcOffset), .srcPitch(srcPitch), .srcTile(srcTile),
    .dstOffset(dstOffset), .dstPitch(dstPitch), .dstTile(dstTile),
    .scissorX(scissorX), .scissorY(scissorY)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doReset(input logic vb);
    @(negedge clk);
    variantB = vb;
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  // Write on a falling edge, captured on the next rising edge, checked at the following falling edge.
  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic testReset;
    chk("R1 startPulse", {31'b0, startPulse}, 0);
    chk("R1 srcX", {18'b0, srcX}, 0);
    chk("R1 width", {18'b0, width}, 0);
    chk("R1 dstOffset", dstOffset, 0);
    chk("R1 srcPitch", {18'b0, srcPitch}, 0);
    chk("R1 dstTile", {31'b0, dstTile}, 0);
    chk("R1 scissorY", {18'b0, scissorY}, 0);
  endtask

  task automatic testSingle;
    wr(5'd0, 32'hFFFF_C123);
    chk("R2 srcX masked", {18'b0, srcX}, 32'h0123);
    chk("R2 no start", {31'b0, startPulse}, 0);
    wr(5'd3, 32'h0000_2ABC);
    chk("R2 dstY", {18'b0, dstY}, 32'h2ABC);
  endtask

  task automatic testPacked;
    wr(5'd6, 32'h1234_5678);
    chk("R3 srcX from Y_X", {18'b0, srcX}, 32'h1678);
    chk("R3 srcY from Y_X", {18'b0, srcY}, 32'h1234);
    wr(5'd9, 32'h0ABC_0DEF);
    chk("R3 dstY from X_Y", {18'b0, dstY}, 32'h0DEF);
    chk("R3 dstX from X_Y", {18'b0, dstX}, 32'h0ABC);
  endtask

  task automatic testLaunch;
    wr(5'd4, 32'h0000_0040);
    chk("R4 width alone pulse", {31'b0, startPulse}, 1);
    chk("R4 width value", {18'b0, width}, 32'h40);
    @(negedge clk);
    chk("R4 pulse one cycle", {31'b0, startPulse}, 0);
    wr(5'd10, 32'h0020_0010);
    chk("R4 height_width pulse", {31'b0, startPulse}, 1);
    chk("R4 height_width width", {18'b0, width}, 32'h10);
    chk("R4 height_width height", {18'b0, height}, 32'h20);
    wr(5'd11, 32'h0030_0007);
    chk("R4 width_height pulse", {31'b0, startPulse}, 1);
    chk("R4 width_height width", {18'b0, width}, 32'h30);
    chk("R4 width_height height", {18'b0, height}, 32'h7);
    wr(5'd12, 32'h0050_0011);
    chk("R4 width_x pulse", {31'b0, startPulse}, 1);
    chk("R4 width_x dstX", {18'b0, dstX}, 32'h11);
    chk("R4 width_x width", {18'b0, width}, 32'h50);
    @(negedge clk);
    chk("R4 width_x pulse ends", {31'b0, startPulse}, 0);
  endtask

  task automatic testNoLaunch;
    wr(5'd5, 32'h0000_0099);
    chk("R5 height alone no pulse", {31'b0, startPulse}, 0);
    chk("R5 height loaded", {18'b0, height}, 32'h99);
    wr(5'd13, 32'h0044_0022);
    chk("R5 height_y no pulse", {31'b0, startPulse}, 0);
    chk("R5 height_y dstY", {18'b0, dstY}, 32'h22);
    chk("R5 height_y height", {18'b0, height}, 32'h44);
  endtask

  task automatic testVariantA;
    wr(5'd18, 32'hAAA0_0ABC);
    chk("R6 srcOffset", srcOffset, 32'h0001_5780);
    chk("R6 srcPitch", {18'b0, srcPitch}, 32'h155);
    chk("R6 srcTile", {31'b0, srcTile}, 1);
    wr(5'd16, 32'h1234_5678);
    chk("R8 A dstOffset", dstOffset, 32'h1234_5670);
    wr(5'd17, 32'h0001_FFFF);
    chk("R9 A dstPitch", {18'b0, dstPitch}, 32'h3FFF);
    chk("R9 A dstTile", {31'b0, dstTile}, 1);
    wr(5'd15, 32'h0000_0123);
    chk("R9 A srcPitch", {18'b0, srcPitch}, 32'h123);
    chk("R9 A srcTile cleared", {31'b0, srcTile}, 0);
  endtask

  task automatic testScissor;
    wr(5'd20, 32'hD234_C567);
    chk("R10 scissorX", {18'b0, scissorX}, 32'h0567);
    chk("R10 scissorY", {18'b0, scissorY}, 32'h1234);
  endtask

  task automatic testUnmapped;
    wr(5'd31, 32'hFFFF_FFFF);
    chk("R11 no pulse", {31'b0, startPulse}, 0);
    chk("R11 width held", {18'b0, width}, 32'h50);
    chk("R11 srcX held", {18'b0, srcX}, 32'h1678);
    chk("R11 dstOffset held", dstOffset, 32'h1234_5670);
    chk("R11 scissorX held", {18'b0, scissorX}, 32'h0567);
  endtask

  task automatic testVariantB;
    doReset(1'b1);
    chk("R1 B srcOffset", srcOffset, 0);
    wr(5'd19, 32'h6941_2345);
    chk("R7 dstOffset", dstOffset, 32'h048D_1400);
    chk("R7 dstPitch", {18'b0, dstPitch}, 32'h2940);
    chk("R7 dstTile", {31'b0, dstTile}, 1);
    wr(5'd14, 32'hFFFF_FFFF);
    chk("R8 B srcOffset", srcOffset, 32'hFFFF_FC00);
    wr(5'd17, 32'h0000_FFFF);
    chk("R9 B dstPitch", {18'b0, dstPitch}, 32'h3FF0);
    chk("R9 B dstTile kept", {31'b0, dstTile}, 1);
    wr(5'd18, 32'h8000_0000);
    chk("R7 bit31 not tile", {31'b0, srcTile}, 0);
  endtask

  initial begin
    doReset(1'b0);
    testReset;
    testSingle;
    testPacked;
    testLaunch;
    testNoLaunch;
    testVariantA;
    testScissor;
    testUnmapped;
    testVariantB;
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #2_000_000;
    total++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule